// File: doc/BRIEF.md
# Prescaled Output-Compare Timer

This block keeps a free-running 16-bit time base and schedules pin events against it. The input clock passes through a selectable divider. Each divider tick advances the counter, and the counter wraps from all-ones back to zero. A master compare channel and a set of single-pin compare channels each hold a target time. When the counter steps onto a channel's target, that channel records a sticky flag. It can also change output pins and request an interrupt.

Software reaches the block through a simple register port. Writes take effect on a clock edge and reads are combinational. Through this port, software loads compare times, reads the counter, chooses what each pin does on a match, forces a pin action at once, and clears flags. Each single-pin channel owns one pin. The master channel can drive a selected group of the same pins to a stored pattern when it matches.

Register addresses: 0x00 counter (read-only), 0x01 divider code, 0x02 pin actions (two bits per channel, channel k at bits 2k+1:2k), 0x03 master pin mask, 0x04 master pin data, 0x05 force strobes, 0x06 flags, 0x07 interrupt enables, 0x08 master compare, 0x10+k compare of channel k. In the flag, enable and force words, bit 0 is the master channel and bit k+1 is channel k. Bit N+1 of the flag and enable words is the overflow, where N is the channel count (default 4).

Top module: `tmr_oc_top`

## Requirements
- R1: The counter is 16 bits wide and reads zero while reset is applied. It advances by one on every divider tick and wraps from 0xFFFF to 0x0000. A write to address 0x00 has no effect on it.
- R2: Divider code 0, 1, 2 and 3 produces exactly 1, 4, 8 and 16 input clocks per counter step, respectively.
- R3: The divider code register resets to 0. It accepts only the first write, and only if that write comes within 64 input clocks after reset. Any other write is ignored, and the code reads back unchanged.
- R4: The overflow flag (flag bit N+1) sets on the edge where the counter wraps to zero.
- R5: A channel's flag sets on the same edge where the counter steps onto that channel's compare value. If a compare register is loaded with the value the counter holds after the write, there is no match until the counter next steps onto that value, one full wrap later.
- R6: A channel's pin action code is 00 for none, 01 for toggle, 10 for drive low and 11 for drive high. A match applies the action on the same edge. A pin's output enable is set when its action is not 00 or when its master mask bit is set.
- R7: Writing 1 to force bit k+1 applies channel k's pin action on that edge. The force sets no flag, raises no interrupt, and leaves the compare register unchanged.
- R8: A flag clears only when 1 is written to its bit at address 0x06. Bits written as 0 keep their value.
- R9: On a master match or a master force, each pin whose mask bit is 1 takes the matching data bit, and pins with mask 0 keep their value. If a single-pin channel acts on the same pin in the same edge, the single-pin action wins.
- R10: The interrupt output is high exactly when some flag is set and its enable bit is also set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 8 | Read address |
| rd_data | output | 16 | Read data, combinational from rd_addr |
| pin_o | output | 4 | Compare pin values |
| pin_oe | output | 4 | Compare pin output enables |
| irq | output | 1 | Interrupt request |

## Verification
A wrong divider phase or a stuck divider code shows up at the counter read port within one 64-clock window. It appears as a step count other than 64, 16, 8 or 4. A compare that fires one edge early or late is caught by polling the counter clock by clock around the target, with the flags and pins sampled on both sides of the expected edge. A wrong action decode or a wrong master/single priority shows up on pin_o on that same edge. A wrong equal-value case becomes visible only after a full 65536-clock wrap, which is why one scenario runs through a whole counter period.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    ACT_OFF  = 2'b00,
    ACT_TOG  = 2'b01,
    ACT_LOW  = 2'b10,
    ACT_HIGH = 2'b11
  } pin_act_e;

  localparam logic [7:0] A_CNT   = 8'h00;
  localparam logic [7:0] A_PRESC = 8'h01;
  localparam logic [7:0] A_ACT   = 8'h02;
  localparam logic [7:0] A_MMASK = 8'h03;
  localparam logic [7:0] A_MDATA = 8'h04;
  localparam logic [7:0] A_FORCE = 8'h05;
  localparam logic [7:0] A_FLAGS = 8'h06;
  localparam logic [7:0] A_IEN   = 8'h07;
  localparam logic [7:0] A_CMPM  = 8'h08;
  localparam logic [7:0] A_CMP0  = 8'h10;

  localparam int unsigned MAX_DIV = 16;

  // clocks per counter step for each divider code
  function automatic logic [4:0] div_limit(input logic [1:0] code);
    logic [4:0] lim;
    case (code)
      2'd0:    lim = 5'd1;
      2'd1:    lim = 5'd4;
      2'd2:    lim = 5'd8;
      default: lim = 5'd16;
    endcase
    return lim;
  endfunction

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int unsigned WIN_CYC = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       presc_we,
  input  logic [1:0] presc_wd,
  output logic [1:0] presc_q,
  output logic       tick
);
  import tmr_pkg::*;

  localparam int unsigned PCNT_W = $clog2(MAX_DIV);
  localparam int unsigned WIN_W  = $clog2(WIN_CYC + 1);

  logic [PCNT_W-1:0] pcnt_q, pcnt_n;
  logic [WIN_W-1:0]  win_q, win_n;
  logic              lock_q, lock_n;
  logic [1:0]        presc_n;
  logic [4:0]        lim;
  logic              win_open;

  always_comb begin
    lim      = div_limit(presc_q);
    tick     = ({1'b0, pcnt_q} >= (lim - 5'd1));
    pcnt_n   = tick ? '0 : pcnt_q + 1'b1;
    win_open = (win_q < WIN_W'(WIN_CYC)) && !lock_q;
    win_n    = (win_q < WIN_W'(WIN_CYC)) ? win_q + 1'b1 : win_q;
    presc_n  = presc_q;
    lock_n   = lock_q;
    if (presc_we && win_open) begin
      presc_n = presc_wd;
      lock_n  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q  <= '0;
      win_q   <= '0;
      lock_q  <= 1'b0;
      presc_q <= 2'd0;
    end else begin
      pcnt_q  <= pcnt_n;
      win_q   <= win_n;
      lock_q  <= lock_n;
      presc_q <= presc_n;
    end
  end

  AST_PRESC_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q || win_q >= WIN_W'(WIN_CYC)) |=> $stable(presc_q)); // R3

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && presc_q != 2'd0 && $stable(presc_q)) |=> !tick); // R2

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             wrap_ev
);

  logic [CNT_W-1:0] cnt_n;

  always_comb begin
    cnt_nxt = cnt_q + 1'b1;
    wrap_ev = tick && (cnt_q == {CNT_W{1'b1}});
    cnt_n   = tick ? cnt_nxt : cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1))); // R1

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q)); // R1

endmodule

// File: rtl/tmr_cmp_chan.sv
module tmr_cmp_chan #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CNT_W-1:0] wd,
  input  logic             tick,
  input  logic [CNT_W-1:0] cnt_nxt,
  output logic [CNT_W-1:0] cmp_q,
  output logic             hit
);

  logic [CNT_W-1:0] cmp_n;

  always_comb begin
    cmp_n = we ? wd : cmp_q;
    // a match is the step onto the stored time, not the dwell on it
    hit   = tick && (cnt_nxt == cmp_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmp_q <= '0;
    else        cmp_q <= cmp_n;
  end

  AST_CMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(cmp_q)); // R7

endmodule

// File: rtl/tmr_pin_ctrl.sv
module tmr_pin_ctrl #(
  parameter int unsigned N_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2*N_CH-1:0] act,
  input  logic [N_CH-1:0]   mmask,
  input  logic [N_CH-1:0]   mdata,
  input  logic              m_fire,
  input  logic [N_CH-1:0]   ch_fire,
  output logic [N_CH-1:0]   pin_q,
  output logic [N_CH-1:0]   pin_oe
);
  import tmr_pkg::*;

  logic [N_CH-1:0] pin_n;

  always_comb begin
    pin_n = pin_q;
    if (m_fire) pin_n = (pin_q & ~mmask) | (mdata & mmask);
    for (int k = 0; k < N_CH; k++) begin
      pin_oe[k] = (pin_act_e'(act[2*k +: 2]) != ACT_OFF) || mmask[k];
      if (ch_fire[k]) begin
        case (pin_act_e'(act[2*k +: 2]))
          ACT_TOG:  pin_n[k] = ~pin_q[k];
          ACT_LOW:  pin_n[k] = 1'b0;
          ACT_HIGH: pin_n[k] = 1'b1;
          default:  pin_n[k] = pin_n[k];
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= '0;
    else        pin_q <= pin_n;
  end

  AST_PIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!m_fire && ch_fire == '0) |=> $stable(pin_q)); // R6

  for (genvar g = 0; g < N_CH; g++) begin : g_chk
    AST_PIN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_fire[g] && act[2*g +: 2] == 2'b11) |=> pin_q[g]); // R6
    AST_PIN_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_fire[g] && act[2*g +: 2] == 2'b01) |=> (pin_q[g] != $past(pin_q[g]))); // R6
    AST_MASTER_UNSEL: assert property (@(posedge clk) disable iff (!rst_n)
      (m_fire && !mmask[g] && !ch_fire[g]) |=> $stable(pin_q[g])); // R9
  end

endmodule

// File: rtl/tmr_oc_top.sv
module tmr_oc_top #(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned N_CH    = 4,
  parameter int unsigned WIN_CYC = 64,
  parameter int unsigned ADDR_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  output logic [N_CH-1:0]   pin_o,
  output logic [N_CH-1:0]   pin_oe,
  output logic              irq
);
  import tmr_pkg::*;

  localparam int unsigned FLG_W = N_CH + 2;
  localparam int unsigned ACT_W = 2 * N_CH;
  localparam int unsigned OVF_B = N_CH + 1;

  // reset synchronizer
  logic rst_meta, rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_i    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_i    <= rst_meta;
    end
  end

  // write decode
  logic            we_presc, we_act, we_mmask, we_mdata, we_force, we_flags, we_ien, we_cmpm;
  logic [N_CH-1:0] we_cmp;

  always_comb begin
    we_presc = wr_en && (wr_addr == ADDR_W'(A_PRESC));
    we_act   = wr_en && (wr_addr == ADDR_W'(A_ACT));
    we_mmask = wr_en && (wr_addr == ADDR_W'(A_MMASK));
    we_mdata = wr_en && (wr_addr == ADDR_W'(A_MDATA));
    we_force = wr_en && (wr_addr == ADDR_W'(A_FORCE));
    we_flags = wr_en && (wr_addr == ADDR_W'(A_FLAGS));
    we_ien   = wr_en && (wr_addr == ADDR_W'(A_IEN));
    we_cmpm  = wr_en && (wr_addr == ADDR_W'(A_CMPM));
    for (int k = 0; k < N_CH; k++)
      we_cmp[k] = wr_en && (wr_addr == ADDR_W'(A_CMP0) + ADDR_W'(k));
  end

  // time base
  logic [1:0]       presc_q;
  logic             tick, wrap_ev;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;

  tmr_prescale #(.WIN_CYC(WIN_CYC)) u_presc (
    .clk(clk), .rst_n(rst_i), .presc_we(we_presc), .presc_wd(wr_data[1:0]),
    .presc_q(presc_q), .tick(tick)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_i), .tick(tick),
    .cnt_q(cnt_q), .cnt_nxt(cnt_nxt), .wrap_ev(wrap_ev)
  );

  // compare channels
  logic [CNT_W-1:0] cmpm_q;
  logic             m_hit;
  logic [CNT_W-1:0] cmp_q [N_CH];
  logic [N_CH-1:0]  ch_hit;

  tmr_cmp_chan #(.CNT_W(CNT_W)) u_cmp_m (
    .clk(clk), .rst_n(rst_i), .we(we_cmpm), .wd(wr_data), .tick(tick),
    .cnt_nxt(cnt_nxt), .cmp_q(cmpm_q), .hit(m_hit)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    tmr_cmp_chan #(.CNT_W(CNT_W)) u_cmp (
      .clk(clk), .rst_n(rst_i), .we(we_cmp[g]), .wd(wr_data), .tick(tick),
      .cnt_nxt(cnt_nxt), .cmp_q(cmp_q[g]), .hit(ch_hit[g])
    );
  end

  // configuration and status registers
  logic [ACT_W-1:0] act_q, act_n;
  logic [N_CH-1:0]  mmask_q, mmask_n, mdata_q, mdata_n;
  logic [FLG_W-1:0] flags_q, flags_n, ien_q, ien_n, set_vec, clr_vec;
  logic [N_CH:0]    frc;

  always_comb begin
    act_n   = we_act   ? wr_data[ACT_W-1:0] : act_q;
    mmask_n = we_mmask ? wr_data[N_CH-1:0]  : mmask_q;
    mdata_n = we_mdata ? wr_data[N_CH-1:0]  : mdata_q;
    ien_n   = we_ien   ? wr_data[FLG_W-1:0] : ien_q;
    frc     = we_force ? wr_data[N_CH:0]    : '0;
    set_vec = {wrap_ev, ch_hit, m_hit};
    clr_vec = we_flags ? wr_data[FLG_W-1:0] : '0;
    flags_n = (flags_q & ~clr_vec) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      act_q   <= '0;
      mmask_q <= '0;
      mdata_q <= '0;
      ien_q   <= '0;
      flags_q <= '0;
    end else begin
      act_q   <= act_n;
      mmask_q <= mmask_n;
      mdata_q <= mdata_n;
      ien_q   <= ien_n;
      flags_q <= flags_n;
    end
  end

  assign irq = |(flags_q & ien_q);

  tmr_pin_ctrl #(.N_CH(N_CH)) u_pins (
    .clk(clk), .rst_n(rst_i), .act(act_q), .mmask(mmask_q), .mdata(mdata_q),
    .m_fire(m_hit || frc[0]), .ch_fire(ch_hit | frc[N_CH:1]),
    .pin_q(pin_o), .pin_oe(pin_oe)
  );

  // read mux
  always_comb begin
    rd_data = '0;
    case (rd_addr)
      ADDR_W'(A_CNT):   rd_data = cnt_q;
      ADDR_W'(A_PRESC): rd_data[1:0] = presc_q;
      ADDR_W'(A_ACT):   rd_data[ACT_W-1:0] = act_q;
      ADDR_W'(A_MMASK): rd_data[N_CH-1:0] = mmask_q;
      ADDR_W'(A_MDATA): rd_data[N_CH-1:0] = mdata_q;
      ADDR_W'(A_FLAGS): rd_data[FLG_W-1:0] = flags_q;
      ADDR_W'(A_IEN):   rd_data[FLG_W-1:0] = ien_q;
      ADDR_W'(A_CMPM):  rd_data = cmpm_q;
      default: begin
        for (int k = 0; k < N_CH; k++)
          if (rd_addr == ADDR_W'(A_CMP0) + ADDR_W'(k)) rd_data = cmp_q[k];
      end
    endcase
  end

  AST_OVF_FLAG: assert property (@(posedge clk) disable iff (!rst_i)
    wrap_ev |=> flags_q[OVF_B]); // R4

  AST_MASTER_FLAG: assert property (@(posedge clk) disable iff (!rst_i)
    m_hit |=> flags_q[0]); // R5

  for (genvar g = 0; g < N_CH; g++) begin : g_fchk
    AST_MATCH_FLAG: assert property (@(posedge clk) disable iff (!rst_i)
      ch_hit[g] |=> flags_q[g+1]); // R5
  end

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_i)
    !we_flags |=> ((flags_q & $past(flags_q)) == $past(flags_q))); // R8

  AST_FORCE_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_i)
    (frc != '0 && set_vec == '0) |=> $stable(flags_q)); // R7

endmodule

// File: tb/tmr_oc_top_tb.sv
module tmr_oc_top_tb;
  localparam int CW = 16;
  localparam int NC = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en;
  logic [7:0]    wr_addr, rd_addr;
  logic [CW-1:0] wr_data, rd_data;
  logic [NC-1:0] pin_o, pin_oe;
  logic          irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tmr_oc_top u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .pin_o(pin_o), .pin_oe(pin_oe), .irq(irq)
  );

  localparam logic [7:0] CNT = 8'h00, PRE = 8'h01, ACT = 8'h02, MMK = 8'h03, MDT = 8'h04,
                         FRC = 8'h05, FLG = 8'h06, IEN = 8'h07, CMPM = 8'h08, CMP0 = 8'h10;

  task automatic chk(input string req, input logic [CW-1:0] got, input logic [CW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [CW-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [CW-1:0] v);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  task automatic wait_cnt(input logic [CW-1:0] tgt);
    logic [CW-1:0] v;
    rd(CNT, v);
    while (v != tgt) begin
      @(negedge clk);
      rd(CNT, v);
    end
  endtask

  task automatic do_reset();
    logic [CW-1:0] v;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rd(CNT, v);
    chk("R1 counter in reset", v, 16'h0000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic measure(input string req, input logic [CW-1:0] exp_steps);
    logic [CW-1:0] a, b;
    rd(CNT, a);
    repeat (64) @(negedge clk);
    rd(CNT, b);
    chk(req, b - a, exp_steps);
  endtask

  task automatic t_reset_state();
    logic [CW-1:0] v;
    do_reset();
    rd(FLG, v); chk("R8 flags after reset", v, 16'h0000);
    rd(PRE, v); chk("R3 divider code after reset", v, 16'h0000);
    chk("R6 pins after reset", {12'h0, pin_o}, 16'h0000);
    chk("R6 enables after reset", {12'h0, pin_oe}, 16'h0000);
    chk("R10 irq after reset", {15'h0, irq}, 16'h0000);
  endtask

  task automatic t_divider();
    logic [CW-1:0] v;
    do_reset();
    wr(PRE, 16'h0001);
    wr(PRE, 16'h0003);
    rd(PRE, v); chk("R3 second write in window ignored", v, 16'h0001);
    measure("R2 divide by 4", 16'd16);
    repeat (80) @(negedge clk);
    wr(PRE, 16'h0000);
    rd(PRE, v); chk("R3 write after window ignored", v, 16'h0001);
    do_reset();
    wr(PRE, 16'h0002);
    measure("R2 divide by 8", 16'd8);
    do_reset();
    wr(PRE, 16'h0003);
    measure("R2 divide by 16", 16'd4);
    do_reset();
    repeat (70) @(negedge clk);
    wr(PRE, 16'h0003);
    rd(PRE, v); chk("R3 late first write ignored", v, 16'h0000);
    measure("R2 divide by 1", 16'd64);
  endtask

  task automatic t_force_high();
    logic [CW-1:0] v;
    wr(IEN, 16'h003F);
    wr(ACT, 16'h0030);          // channel 2 drive high
    wr(FRC, 16'h0008);          // force channel 2
    chk("R7 force drives pin", {12'h0, pin_o}, 16'h0004);
    chk("R6 enable follows action", {12'h0, pin_oe}, 16'h0004);
    rd(FLG, v); chk("R7 force sets no flag", v, 16'h0000);
    chk("R7 force raises no irq", {15'h0, irq}, 16'h0000);
    rd(CMP0 + 8'd2, v); chk("R7 force keeps compare", v, 16'h0000);
  endtask

  task automatic t_toggle_match();
    logic [CW-1:0] c, v;
    wr(ACT, 16'h0034);          // ch1 toggle, ch2 high
    rd(CNT, c);
    wr(CMP0 + 8'd1, c + 16'd40);
    wait_cnt(c + 16'd39);
    rd(FLG, v); chk("R5 no flag before match edge", v, 16'h0000);
    chk("R6 pin unchanged before match", {12'h0, pin_o}, 16'h0004);
    @(negedge clk);
    rd(FLG, v); chk("R5 flag on match edge", v, 16'h0004);
    chk("R6 toggle on match", {12'h0, pin_o}, 16'h0006);
    chk("R10 irq with enabled flag", {15'h0, irq}, 16'h0001);
  endtask

  task automatic t_w1c();
    logic [CW-1:0] v;
    wr(FLG, 16'h0000);
    rd(FLG, v); chk("R8 writing zero keeps flag", v, 16'h0004);
    wr(FLG, 16'h0004);
    rd(FLG, v); chk("R8 writing one clears flag", v, 16'h0000);
    chk("R10 irq drops after clear", {15'h0, irq}, 16'h0000);
  endtask

  task automatic t_master();
    logic [CW-1:0] c, v;
    wr(ACT, 16'h0004);          // ch1 toggle only
    wr(MMK, 16'h0005);
    wr(MDT, 16'h0001);
    chk("R6 enable from mask or action", {12'h0, pin_oe}, 16'h0007);
    rd(CNT, c);
    wr(CMPM, c + 16'd30);
    wait_cnt(c + 16'd29);
    chk("R9 pins before master match", {12'h0, pin_o}, 16'h0006);
    @(negedge clk);
    chk("R9 masked pattern applied", {12'h0, pin_o}, 16'h0003);
    rd(FLG, v); chk("R5 master flag", v, 16'h0001);
  endtask

  task automatic t_priority();
    logic [CW-1:0] c, v;
    wr(FLG, 16'h003F);
    wr(ACT, 16'h0006);          // ch0 low, ch1 toggle
    rd(CNT, c);
    wr(CMPM, c + 16'd30);
    wr(CMP0, c + 16'd30);
    wait_cnt(c + 16'd30);
    chk("R9 single-pin action wins", {12'h0, pin_o}, 16'h0002);
    rd(FLG, v); chk("R5 both flags set", v, 16'h0003);
  endtask

  task automatic t_force_toggle();
    logic [CW-1:0] a, b, v;
    wr(FLG, 16'h003F);
    rd(CMP0 + 8'd1, a);
    wr(FRC, 16'h0004);          // force channel 1 (toggle)
    chk("R7 forced toggle", {12'h0, pin_o}, 16'h0000);
    rd(FLG, v); chk("R7 forced toggle sets no flag", v, 16'h0000);
    chk("R7 forced toggle no irq", {15'h0, irq}, 16'h0000);
    rd(CMP0 + 8'd1, b); chk("R7 compare unchanged", b, a);
  endtask

  task automatic t_cnt_ro();
    logic [CW-1:0] a, b;
    rd(CNT, a);
    wr(CNT, a + 16'h4000);
    rd(CNT, b);
    chk("R1 counter write ignored", b, a + 16'd1);
  endtask

  task automatic t_wrap();
    logic [CW-1:0] c, v;
    wr(ACT, 16'h0000);
    wr(FLG, 16'h003F);
    rd(CNT, c);
    wr(CMP0 + 8'd3, c + 16'd1); // equals the count after this write
    repeat (20) @(negedge clk);
    rd(FLG, v); chk("R5 equal write gives no match", v & 16'h0010, 16'h0000);
    wait_cnt(16'hFFFF);
    rd(FLG, v); chk("R4 no overflow before wrap", v & 16'h0030, 16'h0000);
    @(negedge clk);
    rd(CNT, v); chk("R1 wrap to zero", v, 16'h0000);
    rd(FLG, v); chk("R4 overflow flag on wrap", v & 16'h0020, 16'h0020);
    wait_cnt(c + 16'd1);
    rd(FLG, v); chk("R5 match after full period", v & 16'h0010, 16'h0010);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_divider();
    t_force_high();
    t_toggle_match();
    t_w1c();
    t_master();
    t_priority();
    t_force_toggle();
    t_cnt_ro();
    t_wrap();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule